// File: doc/BRIEF.md
# Halfword Instruction Decoder

This block takes one 16-bit instruction halfword from a fetch stage and turns it into a control bundle for the execute stage of a small 32-bit load/store processor. The bundle gives the format class, the operation code, the register indices, the short immediate, the signed branch displacement, the instruction length in bytes and an illegal-encoding flag. It also carries a few hints for the datapath: the memory access width, zero-extension of narrow loads, the 5-bit shift-amount mask and the special-register-3 capture for the software trap. When a 32-bit extension word follows the halfword, a separate flag is raised so that fetch can deliver that word next.

The decode itself is combinational. Its result sits in one output register behind a valid/ready handshake. A new halfword is taken whenever the register is empty or is being drained in the same cycle. The bundle appears one cycle after the halfword is accepted and holds still while the consumer stalls.

Top module: `vlen_decode`

## Requirements
- R1: The format class is 1 when bit 15 is 0, 2 when bits 15:14 are 10, and 3 when bits 15:14 are 11. It is never 0 on a valid output.
- R2: For format 1, the operation is bits 15:8, register A is bits 7:4 and register B is bits 3:0. The immediate and the displacement are 0.
- R3: For format 2, the operation is bits 13:12 zero-extended, register A is bits 11:8, register B is 0 and the immediate is bits 7:0. All four operations are legal, and every format 2 word is 2 bytes long.
- R4: For format 3, the operation is the condition in bits 13:10 zero-extended. The displacement is bits 9:0 sign-extended and multiplied by two (11 bits). Conditions 10 to 15 are illegal, and every format 3 word is 2 bytes long.
- R5: A legal format 1 word with operation 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 or 0x36..0x39 reports a length of 6 and raises the extension flag. Every other word reports 2 with the flag low.
- R6: A format 1 operation is legal in 0x00..0x0E and 0x19..0x39. Any other value sets the illegal flag. An illegal word reports length 2, extension low, zero-extend, shift-mask and trap-capture low, and width code 2.
- R7: The width code is 0 (byte) for format 1 operations 0x1C..0x1F, 0x36 and 0x37. It is 1 (halfword) for 0x21..0x24, 0x38 and 0x39. It is 2 (word) for all other words.
- R8: The zero-extend flag is high only for the narrow loads 0x1C, 0x1D, 0x21, 0x22, 0x36 and 0x38.
- R9: The shift-mask flag, meaning only the low 5 bits of register B form the amount, is high only for operations 0x27, 0x28 and 0x2D.
- R10: The trap-capture flag, meaning the extension word goes to special register 3, is high only for operation 0x30.
- R11: in_ready equals (not out_valid) or out_ready. An accepted halfword shows its bundle with out_valid high after the next rising edge. A stalled bundle stays unchanged until it is taken, and bundles leave in acceptance order.
- R12: After synchronous reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Halfword offered |
| in_ready | output | 1 | Halfword can be taken this cycle |
| in_word | input | 16 | Instruction halfword |
| out_valid | output | 1 | Bundle present |
| out_ready | input | 1 | Consumer takes the bundle |
| out_fmt | output | 2 | Format class 1, 2 or 3 |
| out_op | output | 8 | Operation code |
| out_ra | output | 4 | Register A index |
| out_rb | output | 4 | Register B index |
| out_imm | output | 8 | Unsigned short immediate |
| out_disp | output | 11 | Signed branch byte displacement |
| out_len | output | 3 | Length in bytes (2 or 6) |
| out_ext | output | 1 | 32-bit extension word follows |
| out_illegal | output | 1 | Undefined encoding |
| out_width | output | 2 | Access width: 0 byte, 1 half, 2 word |
| out_zext | output | 1 | Zero-extend narrow load result |
| out_shamt5 | output | 1 | Mask shift amount to 5 bits |
| out_sr3 | output | 1 | Capture extension word in special register 3 |

## Verification
Every field of a bundle is due exactly one rising edge after the edge on which its halfword was accepted, and it must stay there for as long as out_ready is held low. The bench records each accepted halfword in a queue of expected bundles at the falling edge before the accepting edge. At every falling edge where out_valid is high, it compares all fields against the head of that queue, so a value that drifts during a stall is caught as well as a wrong one. in_ready is checked against the handshake rule at every falling edge. The head is popped when out_valid and out_ready are both high.

// File: rtl/vd_pkg.sv
package vd_pkg;
  localparam int INSN_W = 16;
  localparam int OP_W   = 8;
  localparam int REG_W  = 4;
  localparam int IMM_W  = 8;
  localparam int DISP_W = 11;
  localparam int LEN_W  = 3;
  localparam int COND_W = 4;

  localparam logic [OP_W-1:0]   OP_LOW_LAST   = 8'h0E;
  localparam logic [OP_W-1:0]   OP_HIGH_FIRST = 8'h19;
  localparam logic [OP_W-1:0]   OP_HIGH_LAST  = 8'h39;
  localparam logic [OP_W-1:0]   OP_TRAP       = 8'h30;
  localparam logic [COND_W-1:0] COND_LAST     = 4'd9;
  localparam logic [LEN_W-1:0]  LEN_SHORT     = 3'd2;
  localparam logic [LEN_W-1:0]  LEN_LONG      = 3'd6;

  typedef enum logic [1:0] {FMT_NONE = 2'd0, FMT_ONE = 2'd1, FMT_TWO = 2'd2, FMT_THREE = 2'd3} fmt_e;
  typedef enum logic [1:0] {AW_BYTE = 2'd0, AW_HALF = 2'd1, AW_WORD = 2'd2} width_e;

  typedef struct packed {
    fmt_e              fmt;
    logic [OP_W-1:0]   op;
    logic [REG_W-1:0]  ra;
    logic [REG_W-1:0]  rb;
    logic [IMM_W-1:0]  imm;
    logic [DISP_W-1:0] disp;
    logic [LEN_W-1:0]  len;
    logic              ext;
    logic              illegal;
    width_e            width;
    logic              zext;
    logic              shamt5;
    logic              sr3;
  } dec_t;

  localparam int DEC_W = $bits(dec_t);

  function automatic logic op_defined(input logic [OP_W-1:0] op);
    return (op <= OP_LOW_LAST) || (op >= OP_HIGH_FIRST && op <= OP_HIGH_LAST);
  endfunction

  function automatic logic op_has_ext(input logic [OP_W-1:0] op);
    case (op)
      8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D, 8'h1A, 8'h1B,
      8'h1D, 8'h1F, 8'h20, 8'h22, 8'h24, 8'h30,
      8'h36, 8'h37, 8'h38, 8'h39: return 1'b1;
      default:                    return 1'b0;
    endcase
  endfunction

  function automatic width_e op_width(input logic [OP_W-1:0] op);
    case (op)
      8'h1C, 8'h1D, 8'h1E, 8'h1F, 8'h36, 8'h37: return AW_BYTE;
      8'h21, 8'h22, 8'h23, 8'h24, 8'h38, 8'h39: return AW_HALF;
      default:                                  return AW_WORD;
    endcase
  endfunction

  function automatic logic op_zext(input logic [OP_W-1:0] op);
    case (op)
      8'h1C, 8'h1D, 8'h21, 8'h22, 8'h36, 8'h38: return 1'b1;
      default:                                  return 1'b0;
    endcase
  endfunction

  function automatic logic op_shift(input logic [OP_W-1:0] op);
    return (op == 8'h27) || (op == 8'h28) || (op == 8'h2D);
  endfunction
endpackage

// File: rtl/vd_fields.sv
module vd_fields
  import vd_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output dec_t              dec
);
  logic [OP_W-1:0]   f1_op;
  logic [COND_W-1:0] f3_cond;
  logic              f1_ok;

  assign f1_op   = word[15:8];
  assign f3_cond = word[13:10];
  assign f1_ok   = op_defined(f1_op);

  always_comb begin
    dec         = '0;
    dec.len     = LEN_SHORT;
    dec.width   = AW_WORD;
    if (!word[15]) begin
      dec.fmt     = FMT_ONE;
      dec.op      = f1_op;
      dec.ra      = word[7:4];
      dec.rb      = word[3:0];
      dec.illegal = !f1_ok;
      if (f1_ok) begin
        dec.ext    = op_has_ext(f1_op);
        dec.len    = op_has_ext(f1_op) ? LEN_LONG : LEN_SHORT;
        dec.width  = op_width(f1_op);
        dec.zext   = op_zext(f1_op);
        dec.shamt5 = op_shift(f1_op);
        dec.sr3    = (f1_op == OP_TRAP);
      end
    end else if (!word[14]) begin
      dec.fmt = FMT_TWO;
      dec.op  = {{(OP_W-2){1'b0}}, word[13:12]};
      dec.ra  = word[11:8];
      dec.imm = word[7:0];
    end else begin
      dec.fmt     = FMT_THREE;
      dec.op      = {{(OP_W-COND_W){1'b0}}, f3_cond};
      dec.disp    = {word[9:0], 1'b0};
      dec.illegal = (f3_cond > COND_LAST);
    end
  end
endmodule

// File: rtl/vd_outreg.sv
module vd_outreg #(
  parameter int DATA_W     = 8,
  parameter bit RESET_DATA = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)           out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  generate
    if (RESET_DATA) begin : g_rst_data
      always_ff @(posedge clk) begin
        if (rst)       out_data <= '0;
        else if (take) out_data <= in_data;
      end
    end else begin : g_plain_data
      always_ff @(posedge clk) begin
        if (take) out_data <= in_data;
      end
    end
  endgenerate
endmodule

// File: rtl/vlen_decode.sv
module vlen_decode
  import vd_pkg::*;
#(
  parameter bit RESET_DATA = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_fmt,
  output logic [OP_W-1:0]   out_op,
  output logic [REG_W-1:0]  out_ra,
  output logic [REG_W-1:0]  out_rb,
  output logic [IMM_W-1:0]  out_imm,
  output logic [DISP_W-1:0] out_disp,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_ext,
  output logic              out_illegal,
  output logic [1:0]        out_width,
  output logic              out_zext,
  output logic              out_shamt5,
  output logic              out_sr3
);
  dec_t             d_comb;
  dec_t             d_q;
  logic [DEC_W-1:0] d_q_bits;

  vd_fields u_fields (
    .word (in_word),
    .dec  (d_comb)
  );

  vd_outreg #(
    .DATA_W     (DEC_W),
    .RESET_DATA (RESET_DATA)
  ) u_reg (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (d_comb),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (d_q_bits)
  );

  assign d_q         = dec_t'(d_q_bits);
  assign out_fmt     = d_q.fmt;
  assign out_op      = d_q.op;
  assign out_ra      = d_q.ra;
  assign out_rb      = d_q.rb;
  assign out_imm     = d_q.imm;
  assign out_disp    = d_q.disp;
  assign out_len     = d_q.len;
  assign out_ext     = d_q.ext;
  assign out_illegal = d_q.illegal;
  assign out_width   = d_q.width;
  assign out_zext    = d_q.zext;
  assign out_shamt5  = d_q.shamt5;
  assign out_sr3     = d_q.sr3;
endmodule

// File: rtl/vlen_decode_chk.sv
module vlen_decode_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [1:0]  out_fmt,
  input logic [7:0]  out_op,
  input logic [3:0]  out_ra,
  input logic [3:0]  out_rb,
  input logic [7:0]  out_imm,
  input logic [10:0] out_disp,
  input logic [2:0]  out_len,
  input logic        out_ext,
  input logic        out_illegal,
  input logic        out_zext,
  input logic        out_shamt5,
  input logic        out_sr3
);
  p_fmt_nonzero_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_fmt != 2'd0);

  p_fmt2_short_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fmt == 2'd2) |-> (!out_illegal && out_len == 3'd2));

  p_fmt3_short_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fmt == 2'd3) |-> (!out_ext && out_len == 3'd2));

  p_len_pair_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_len == 3'd6 && out_ext) || (out_len == 3'd2 && !out_ext)));

  p_illegal_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (!out_ext && !out_zext && !out_shamt5 && !out_sr3));

  p_shift_fmt1_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_shamt5) |-> (out_fmt == 2'd1 && !out_ext));

  p_trap_ext_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sr3) |-> (out_ext && out_op == 8'h30));

  p_ready_empty_r11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  p_accept_shows_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_ra) &&
      $stable(out_rb) && $stable(out_imm) && $stable(out_disp) && $stable(out_len) &&
      $stable(out_fmt) && $stable(out_illegal)));

  p_reset_empty_r12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);
endmodule

bind vlen_decode vlen_decode_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_fmt     (out_fmt),
  .out_op      (out_op),
  .out_ra      (out_ra),
  .out_rb      (out_rb),
  .out_imm     (out_imm),
  .out_disp    (out_disp),
  .out_len     (out_len),
  .out_ext     (out_ext),
  .out_illegal (out_illegal),
  .out_zext    (out_zext),
  .out_shamt5  (out_shamt5),
  .out_sr3     (out_sr3)
);

// File: tb/vlen_decode_test.sv
module vlen_decode_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = 16'h0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_fmt;
  logic [7:0]  out_op;
  logic [3:0]  out_ra, out_rb;
  logic [7:0]  out_imm;
  logic [10:0] out_disp;
  logic [2:0]  out_len;
  logic        out_ext, out_illegal;
  logic [1:0]  out_width;
  logic        out_zext, out_shamt5, out_sr3;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit stall_mode = 1'b0;
  int cyc = 0;

  typedef struct {
    int fmt, op, ra, rb, imm, disp, len, ext, ill, width, zext, sh, sr3;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  vlen_decode uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_fmt(out_fmt), .out_op(out_op),
    .out_ra(out_ra), .out_rb(out_rb), .out_imm(out_imm), .out_disp(out_disp),
    .out_len(out_len), .out_ext(out_ext), .out_illegal(out_illegal), .out_width(out_width),
    .out_zext(out_zext), .out_shamt5(out_shamt5), .out_sr3(out_sr3)
  );

  function automatic bit in_set(int v, int s[]);
    foreach (s[i]) if (s[i] == v) return 1'b1;
    return 1'b0;
  endfunction

  function automatic exp_t model(logic [15:0] w);
    exp_t e;
    int x;
    e = '{default: 0};
    e.len = 2; e.width = 2;
    if (w[15] == 1'b0) begin
      x = int'(w[15:8]);
      e.fmt = 1; e.op = x; e.ra = int'(w[7:4]); e.rb = int'(w[3:0]);
      e.ill = !((x >= 0 && x <= 14) || (x >= 25 && x <= 57));
      if (!e.ill) begin
        e.ext = in_set(x, '{1, 3, 8, 9, 12, 13, 26, 27, 29, 31, 32, 34, 36, 48, 54, 55, 56, 57});
        e.len = e.ext ? 6 : 2;
        if (in_set(x, '{28, 29, 30, 31, 54, 55})) e.width = 0;
        else if (in_set(x, '{33, 34, 35, 36, 56, 57})) e.width = 1;
        e.zext = in_set(x, '{28, 29, 33, 34, 54, 56});
        e.sh   = in_set(x, '{39, 40, 45});
        e.sr3  = (x == 48);
      end
    end else if (w[14] == 1'b0) begin
      e.fmt = 2; e.op = int'(w[13:12]); e.ra = int'(w[11:8]); e.imm = int'(w[7:0]);
    end else begin
      e.fmt = 3; e.op = int'(w[13:10]);
      x = int'(w[9:0]);
      if (x >= 512) x = x - 1024;
      e.disp = (x * 2) & 32'h7FF;
      e.ill = (e.op > 9);
    end
    return e;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // Monitor at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      check("R11", "in_ready rule", int'(in_ready), int'(!out_valid || out_ready));
      check("R11", "out_valid vs pending", int'(out_valid), int'(q.size() != 0));
      if (out_valid && q.size() != 0) begin
        check("R1",  "fmt",     int'(out_fmt),     q[0].fmt);
        check("R2",  "op",      int'(out_op),      q[0].op);
        check("R2",  "ra",      int'(out_ra),      q[0].ra);
        check("R2",  "rb",      int'(out_rb),      q[0].rb);
        check("R3",  "imm",     int'(out_imm),     q[0].imm);
        check("R4",  "disp",    int'(out_disp),    q[0].disp);
        check("R5",  "len",     int'(out_len),     q[0].len);
        check("R5",  "ext",     int'(out_ext),     q[0].ext);
        check("R6",  "illegal", int'(out_illegal), q[0].ill);
        check("R7",  "width",   int'(out_width),   q[0].width);
        check("R8",  "zext",    int'(out_zext),    q[0].zext);
        check("R9",  "shamt5",  int'(out_shamt5),  q[0].sh);
        check("R10", "sr3",     int'(out_sr3),     q[0].sr3);
        if (out_ready) void'(q.pop_front());
      end
      if (in_valid && in_ready) q.push_back(model(in_word));
    end
  end

  // Consumer readiness, changed just after the rising edge.
  always @(posedge clk) begin
    #1;
    cyc++;
    out_ready = stall_mode ? ((cyc % 4) >= 2) : 1'b1;
  end

  task automatic send(logic [15:0] w);
    bit acc;
    in_valid = 1'b1;
    in_word  = w;
    do begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk);
      #1;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R12", "out_valid after reset", int'(out_valid), 0);
    check("R12", "in_ready after reset",  int'(in_ready),  1);
    @(posedge clk); #1;

    // Every format 1 opcode, back to back (R2, R5..R10).
    for (int op = 0; op < 128; op++)
      send({op[7:0], op[3:0] ^ 4'hA, ~op[3:0]});

    // Format 2: all four operations with edge immediates (R3).
    for (int o = 0; o < 4; o++) begin
      send({2'b10, o[1:0], 4'h0, 8'h00});
      send({2'b10, o[1:0], 4'hF, 8'hFF});
      send({2'b10, o[1:0], o[3:0] + 4'd5, 8'h5C});
    end

    // Format 3: every condition with extreme displacements (R4).
    for (int c = 0; c < 16; c++) begin
      send({2'b11, c[3:0], 10'h000});
      send({2'b11, c[3:0], 10'h1FF});
      send({2'b11, c[3:0], 10'h200});
      send({2'b11, c[3:0], 10'h3FF});
      send({2'b11, c[3:0], 10'h155});
    end

    // Consumer stalls with idle gaps (R11).
    stall_mode = 1'b1;
    for (int k = 0; k < 64; k++) begin
      send({k[5:0] + 8'h0C, 4'h3, 4'h7});
      if (k % 3 == 0) begin
        @(posedge clk); #1;
      end
    end
    send(16'h3012);
    send(16'h2D45);
    send(16'hA9FE);
    send(16'hFC01);

    stall_mode = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    check("R11", "all bundles delivered in order", q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule